// File: doc/BRIEF.md
# Serial Audio Clock Master/Slave Generator

This block provides the frame (LR) clock and the bit clock for a serial audio link. It runs from a source clock at 256 times the highest sampling rate. When it is master, it divides that clock down and drives both link clocks through output enables. When it is slave, it releases those pins and passes the incoming link clocks on to the rest of the audio path. It also produces a gated copy of the source clock for external converters.

Two conditions must both hold for the master role. A strap pin, sampled once after reset, must be high, and a run-time command bit must request master. While it is master, the frame rate can be the full sampling rate or two thirds of it. The bit clock runs at 32 or 64 times the frame rate. The block picks up new rate settings, and a request to leave the master role, only at a frame boundary. With the strap high, the master clock pin is an output and can be gated by a command. With the strap low, that pin is left as an input and feeds the chip its operating clock.

Top module: `audio_clk_gen`

## Requirements
- R1: Link clock outputs are enabled (`bck_oe_o`, `lr_oe_o` high) only when the captured strap is high and `cmd_master_i` is 1; in every other case both enables stay low.
- R2: As master, one LR period lasts 256 source cycles when `cmd_slow_i`=0 and 384 when `cmd_slow_i`=1, with high and low phases of exactly half that each.
- R3: As master, one bit-clock period lasts LR period / 32 source cycles when `cmd_wide_i`=0 and LR period / 64 when `cmd_wide_i`=1 (8, 4, 12 or 6 cycles), with equal high and low phases.
- R4: Every LR transition happens in the same source cycle as a falling edge of the bit clock. A frame starts with LR low and bit clock low, and LR is high for its second half.
- R5: A change of `cmd_slow_i`/`cmd_wide_i`, or a drop of `cmd_master_i`, takes effect only at the next frame boundary. No partial frame is emitted, so master output always lasts a whole number of frames.
- R6: With the enables low, `bck_o` and `lr_o` are 0, and `bck_use_o`/`lr_use_o` follow `bck_i`/`lr_i`. With the enables high, they follow the generated clocks.
- R7: The strap is sampled at the first source clock edge after reset and ignored afterwards until the next reset.
- R8: `mck_oe_o` equals the captured strap. `mck_o` copies `clk_i` while the strap is high and `cmd_mck_en_i`=1, and is otherwise low. The gate opens and closes only while `clk_i` is low, so every `mck_o` pulse is a full half period.
- R9: During reset, all outputs that do not come straight from an input are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock, 256x maximum sampling rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 1 | Role strap; high permits master role |
| cmd_master_i | input | 1 | Command: 1 requests master role |
| cmd_slow_i | input | 1 | Command: 1 selects two-thirds frame rate |
| cmd_wide_i | input | 1 | Command: 1 selects 64x bit clock, 0 selects 32x |
| cmd_mck_en_i | input | 1 | Command: 1 lets master clock out |
| bck_i | input | 1 | Incoming bit clock (slave) |
| lr_i | input | 1 | Incoming LR clock (slave) |
| bck_o | output | 1 | Generated bit clock |
| bck_oe_o | output | 1 | Bit clock pin drive enable |
| lr_o | output | 1 | Generated LR clock |
| lr_oe_o | output | 1 | LR pin drive enable |
| bck_use_o | output | 1 | Bit clock in use by the audio path |
| lr_use_o | output | 1 | LR clock in use by the audio path |
| mck_o | output | 1 | Gated master clock |
| mck_oe_o | output | 1 | Master clock pin drive enable |

## Verification
The assertions assume three things about the inputs. The strap is steady around reset release. The command bits change in step with `clk_i`. The incoming link clocks matter only while the block is slave. The stimulus moves every input at the falling edge of `clk_i` and holds the strap across each release. It changes the rate commands at arbitrary points inside a frame and toggles the master clock gate while the clock is high, so the frame-boundary and glitch-free rules are exercised where they matter.

// File: rtl/audio_clk_pkg.sv
`timescale 1ns/1ps
package audio_clk_pkg;
  typedef struct packed {
    logic slow;  // two-thirds frame rate
    logic wide;  // 64x bit clock
  } rate_cfg_t;
endpackage

// File: rtl/audio_role_ctrl.sv
`timescale 1ns/1ps
module audio_role_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  input  logic cmd_master_i,
  input  logic frame_end_i,
  output logic strap_o,
  output logic master_o
);
  logic taken_q, strap_q, master_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q <= 1'b0;
      strap_q <= 1'b0;
    end else if (!taken_q) begin
      taken_q <= 1'b1;
      strap_q <= strap_i;
    end
  end

  // leaving master waits for a frame end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) master_q <= 1'b0;
    else if (!master_q || frame_end_i) master_q <= strap_q & cmd_master_i;
  end

  assign strap_o  = strap_q;
  assign master_o = master_q;

  assert_strap_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_q |=> $stable(strap_q));
  assert_master_needs_strap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_q |-> strap_q);
endmodule

// File: rtl/audio_frame_div.sv
`timescale 1ns/1ps
module audio_frame_div
  import audio_clk_pkg::*;
#(
  parameter int LR_DIV   = 256,
  parameter int RATIO_LO = 32,
  parameter int RATIO_HI = 64
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  rate_cfg_t cfg_i,
  output logic      frame_end_o,
  output logic      bck_o,
  output logic      lr_o,
  output logic      oe_o
);
  localparam int FRAME_SLOW = LR_DIV * 3 / 2;
  localparam int CW = $clog2(FRAME_SLOW + 1);
  localparam int BW = $clog2(FRAME_SLOW / RATIO_LO + 1);
  localparam int BIT_FL = LR_DIV / RATIO_LO;
  localparam int BIT_FH = LR_DIV / RATIO_HI;
  localparam int BIT_SL = FRAME_SLOW / RATIO_LO;
  localparam int BIT_SH = FRAME_SLOW / RATIO_HI;

  rate_cfg_t       cfg_q;
  logic [CW-1:0]   cnt_q, frame_len, frame_half;
  logic [BW-1:0]   bcnt_q, bit_len, bit_half;
  logic            bck_q, lr_q, oe_q, frame_end;

  always_comb begin
    frame_len = cfg_q.slow ? CW'(FRAME_SLOW) : CW'(LR_DIV);
    unique case ({cfg_q.slow, cfg_q.wide})
      2'b00:   bit_len = BW'(BIT_FL);
      2'b01:   bit_len = BW'(BIT_FH);
      2'b10:   bit_len = BW'(BIT_SL);
      default: bit_len = BW'(BIT_SH);
    endcase
    frame_half = frame_len >> 1;
    bit_half   = bit_len >> 1;
    frame_end  = run_i && (cnt_q == frame_len - CW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bcnt_q <= '0;
      cfg_q  <= '0;
      bck_q  <= 1'b0;
      lr_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      bcnt_q <= '0;
      cfg_q  <= cfg_i;
      bck_q  <= 1'b0;
      lr_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      oe_q  <= 1'b1;
      bck_q <= (bcnt_q >= bit_half);
      lr_q  <= (cnt_q >= frame_half);
      if (frame_end) begin
        cnt_q  <= '0;
        bcnt_q <= '0;
        cfg_q  <= cfg_i;
      end else begin
        cnt_q  <= cnt_q + CW'(1);
        bcnt_q <= (bcnt_q == bit_len - BW'(1)) ? '0 : bcnt_q + BW'(1);
      end
    end
  end

  assign frame_end_o = frame_end;
  assign bck_o = bck_q;
  assign lr_o  = lr_q;
  assign oe_o  = oe_q;

  assert_frame_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < frame_len);
  assert_bit_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcnt_q < bit_len);
  assert_lr_on_bck_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lr_q != $past(lr_q)) |-> (!bck_q && $past(bck_q)));
  assert_cfg_at_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q != $past(cfg_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/audio_mck_gate.sv
`timescale 1ns/1ps
module audio_mck_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mck_o
);
  logic en_q;

  // enable moves only on the falling edge, while the clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign mck_o = clk_i & en_q;
endmodule

// File: rtl/audio_clk_gen.sv
`timescale 1ns/1ps
module audio_clk_gen
  import audio_clk_pkg::*;
#(
  parameter int LR_DIV   = 256,
  parameter int RATIO_LO = 32,
  parameter int RATIO_HI = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  input  logic cmd_master_i,
  input  logic cmd_slow_i,
  input  logic cmd_wide_i,
  input  logic cmd_mck_en_i,
  input  logic bck_i,
  input  logic lr_i,
  output logic bck_o,
  output logic bck_oe_o,
  output logic lr_o,
  output logic lr_oe_o,
  output logic bck_use_o,
  output logic lr_use_o,
  output logic mck_o,
  output logic mck_oe_o
);
  logic      strap_q, master, frame_end, gen_bck, gen_lr, gen_oe;
  rate_cfg_t cmd_cfg;

  assign cmd_cfg = '{slow: cmd_slow_i, wide: cmd_wide_i};

  audio_role_ctrl u_role (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strap_i      (strap_i),
    .cmd_master_i (cmd_master_i),
    .frame_end_i  (frame_end),
    .strap_o      (strap_q),
    .master_o     (master)
  );

  audio_frame_div #(
    .LR_DIV   (LR_DIV),
    .RATIO_LO (RATIO_LO),
    .RATIO_HI (RATIO_HI)
  ) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (master),
    .cfg_i       (cmd_cfg),
    .frame_end_o (frame_end),
    .bck_o       (gen_bck),
    .lr_o        (gen_lr),
    .oe_o        (gen_oe)
  );

  audio_mck_gate u_mck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (strap_q & cmd_mck_en_i),
    .mck_o  (mck_o)
  );

  assign bck_o     = gen_bck;
  assign lr_o      = gen_lr;
  assign bck_oe_o  = gen_oe;
  assign lr_oe_o   = gen_oe;
  assign bck_use_o = gen_oe ? gen_bck : bck_i;
  assign lr_use_o  = gen_oe ? gen_lr  : lr_i;
  assign mck_oe_o  = strap_q;

  assert_oe_needs_strap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bck_oe_o |-> (strap_q && lr_oe_o));
  assert_quiet_when_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bck_oe_o |-> (!bck_o && !lr_o));
  assert_mck_only_with_strap_R8: assert property (@(negedge clk_i) disable iff (!rst_ni)
    mck_o |-> mck_oe_o);
endmodule

// File: tb/audio_clk_gen_test.sv
`timescale 1ns/1ps
module audio_clk_gen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0, c_master = 1'b0, c_slow = 1'b0, c_wide = 1'b0, c_mck = 1'b0;
  logic b_in = 1'b0, l_in = 1'b0;
  logic bck, bck_oe, lr, lr_oe, bck_use, lr_use, mck, mck_oe;

  int n_checks = 0, n_err = 0;
  int lr_runs[$];
  int bck_runs[$];
  logic lr_first;
  int align_err;
  int glitch = 0;
  longint t_rise = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_clk_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .cmd_master_i(c_master),
    .cmd_slow_i(c_slow), .cmd_wide_i(c_wide), .cmd_mck_en_i(c_mck),
    .bck_i(b_in), .lr_i(l_in), .bck_o(bck), .bck_oe_o(bck_oe), .lr_o(lr),
    .lr_oe_o(lr_oe), .bck_use_o(bck_use), .lr_use_o(lr_use), .mck_o(mck),
    .mck_oe_o(mck_oe)
  );

  always @(posedge mck) t_rise = $time;
  always @(negedge mck) if (($time - t_rise) != CLK_PERIOD/2) glitch++;

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; strap = s; c_master = 1'b0; c_mck = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic start_master();
    @(negedge clk);
    c_master = 1'b1;
    for (int i = 0; i < 20 && !bck_oe; i++) @(negedge clk);
  endtask

  task automatic observe(input int n);
    logic lp, bp;
    int ll, bl;
    lr_runs.delete(); bck_runs.delete(); align_err = 0;
    lp = lr; bp = bck; lr_first = lr; ll = 1; bl = 1;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      if (lr !== lp) begin
        lr_runs.push_back(ll); ll = 1;
        if (!(bp === 1'b1 && bck === 1'b0)) align_err++;
      end else ll++;
      if (bck !== bp) begin bck_runs.push_back(bl); bl = 1; end else bl++;
      lp = lr; bp = bck;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9: reset state
    strap = 1'b1; c_master = 1'b1; c_mck = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", "outputs in reset", {bck, bck_oe, lr, lr_oe, mck, mck_oe}, 0);

    // R2 R3 R4: sweep of all rate/ratio settings
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 2; w++) begin
        int per, bper, bad_lr, bad_bck;
        do_reset(1'b1);
        c_slow = s[0]; c_wide = w[0];
        start_master();
        check("R1", "oe with strap and command", {bck_oe, lr_oe}, 3);
        per  = s ? 384 : 256;
        bper = per / (w ? 64 : 32);
        observe(3 * per);
        bad_lr = 0; bad_bck = 0;
        foreach (lr_runs[k]) if (lr_runs[k] != per/2) bad_lr++;
        foreach (bck_runs[k]) if (bck_runs[k] != bper/2) bad_bck++;
        check("R2", $sformatf("lr run count s%0d w%0d", s, w), lr_runs.size(), 5);
        check("R2", $sformatf("lr half period s%0d w%0d", s, w), bad_lr, 0);
        check("R3", $sformatf("bck half period s%0d w%0d", s, w), bad_bck, 0);
        check("R4", $sformatf("lr starts low s%0d w%0d", s, w), int'(lr_first), 0);
        check("R4", $sformatf("lr on bck fall s%0d w%0d", s, w), align_err, 0);
      end
    end

    // R5: rate change mid-frame
    begin
      int bad_b, acc, exp_b;
      do_reset(1'b1);
      c_slow = 1'b0; c_wide = 1'b0;
      start_master();
      fork
        observe(1024);
        begin repeat (100) @(negedge clk); c_slow = 1'b1; c_wide = 1'b1; end
      join
      check("R5", "lr runs after change", lr_runs.size(), 5);
      check("R5", "lr run0", lr_runs[0], 128);
      check("R5", "lr run1", lr_runs[1], 128);
      check("R5", "lr run2", lr_runs[2], 192);
      check("R5", "lr run4", lr_runs[4], 192);
      bad_b = 0; acc = 0;
      foreach (bck_runs[k]) begin
        exp_b = (acc < 256) ? 4 : 3;
        if (bck_runs[k] != exp_b) bad_b++;
        acc += bck_runs[k];
      end
      check("R5", "bck runs across change", bad_b, 0);
    end

    // R5: leaving master finishes the frame
    begin
      int high;
      do_reset(1'b1);
      c_slow = 1'b0; c_wide = 1'b0;
      start_master();
      high = 0;
      for (int i = 0; i < 1200; i++) begin
        if (bck_oe) high++;
        if (i == 300) c_master = 1'b0;
        @(negedge clk);
      end
      check("R5", "master cycles after drop", high, 512);
      check("R6", "pins quiet after drop", {bck, lr, bck_oe, lr_oe}, 0);
    end

    // R1 R6: strap low with master command, then strap high with slave command
    for (int m = 0; m < 2; m++) begin
      int oe_seen, bad_use;
      do_reset(m ? 1'b1 : 1'b0);
      c_master = m ? 1'b0 : 1'b1;
      oe_seen = 0; bad_use = 0;
      for (int i = 0; i < 600; i++) begin
        b_in = i[1]; l_in = i[6];
        #1;
        if (bck_use !== b_in || lr_use !== l_in) bad_use++;
        @(negedge clk);
        if (bck_oe || lr_oe) oe_seen++;
      end
      check("R1", $sformatf("no oe in slave case %0d", m), oe_seen, 0);
      check("R6", $sformatf("slave clocks pass case %0d", m), bad_use, 0);
    end

    // R6: master path uses generated clocks
    begin
      int bad_use;
      do_reset(1'b1);
      c_slow = 1'b0; c_wide = 1'b1;
      start_master();
      bad_use = 0;
      for (int i = 0; i < 300; i++) begin
        b_in = ~bck; l_in = ~lr;
        #1;
        if (bck_use !== bck || lr_use !== lr) bad_use++;
        @(negedge clk);
      end
      check("R6", "master uses generated clocks", bad_use, 0);
    end

    // R7: strap changes after reset are ignored
    begin
      int oe_seen;
      do_reset(1'b0);
      strap = 1'b1; c_master = 1'b1;
      oe_seen = 0;
      for (int i = 0; i < 600; i++) begin
        @(negedge clk);
        if (bck_oe || mck_oe) oe_seen++;
      end
      check("R7", "late strap high ignored", oe_seen, 0);
      do_reset(1'b1);
      start_master();
      strap = 1'b0;
      repeat (600) @(negedge clk);
      check("R7", "late strap low ignored", {bck_oe, mck_oe}, 3);
    end

    // R8: master clock gate
    begin
      do_reset(1'b1);
      glitch = 0;
      check("R8", "mck pin driven with strap", int'(mck_oe), 1);
      c_mck = 1'b1;
      repeat (3) @(negedge clk);
      @(posedge clk); #2;
      check("R8", "mck high phase", int'(mck), 1);
      @(negedge clk); #2;
      check("R8", "mck low phase", int'(mck), 0);
      @(posedge clk); #1;
      c_mck = 1'b0;
      repeat (3) @(negedge clk);
      @(posedge clk); #2;
      check("R8", "mck stopped", int'(mck), 0);
      #1; c_mck = 1'b1;
      repeat (3) @(negedge clk);
      @(posedge clk); #2;
      check("R8", "mck restarted", int'(mck), 1);
      @(posedge clk); #3; c_mck = 1'b0;
      repeat (4) @(negedge clk);
      check("R8", "no short mck pulses", glitch, 0);
      do_reset(1'b0);
      c_mck = 1'b1;
      repeat (3) @(negedge clk);
      @(posedge clk); #2;
      check("R8", "mck off with strap low", {mck, mck_oe}, 0);
    end

    finish_run();
  end
endmodule